// File: doc/BRIEF.md
# Aligned Byte-Lane Load/Store Unit

This block sits between a processor datapath and a memory that is one 32-bit word wide. The datapath issues byte, halfword and word loads and stores. For each request the block checks natural alignment and flags a fault when the check fails. For accesses that pass, it produces a word-aligned memory address and the byte enables, and it moves store data onto the byte lanes it belongs to. One cycle later it takes the returned memory word and turns it into a right-justified load result. That result is zero-extended or sign-extended, depending on a per-request flag.

A mode input chooses the byte order at run time. With little-endian order, the lowest address holds the least significant byte of a value, and address offset `o` inside the word maps to lane `o` (lane 0 is bits 7:0). With big-endian order, the lowest address holds the most significant byte, and the lanes are mirrored: offset `o` maps to lane `3-o`. Put simply, an access of `n` bytes at offset `o` starts at lane `o` in little-endian mode and at lane `4-n-o` in big-endian mode. Inside its lanes the value keeps its natural bit order.

The control is a two-state machine. In `ST_IDLE`, no load result is owed. In `ST_LOAD_WAIT`, a load was accepted on the previous cycle, and its result is presented with `load_valid` while the memory data is on `mem_rdata`. The transition `accept_load` enters or stays in `ST_LOAD_WAIT` whenever a non-faulting load is presented. Back-to-back loads are therefore allowed. The transition `drain` returns to `ST_IDLE` on any cycle without such a load.

Top module: `lsu_lane_unit`

## Requirements
- R1: A byte access (`req_size` = 0) never faults, whatever its address.
- R2: A halfword access (`req_size` = 1) faults exactly when address bit 0 is 1. A word access (`req_size` = 2) faults when address bits 1:0 are not 00. The reserved size code 3 always faults. `fault` is low when `req_valid` is low.
- R3: When a request faults, `mem_req`, `mem_we` and all four bits of `mem_be` are 0, `mem_wdata` is 0, and no `load_valid` follows on the next cycle.
- R4: In little-endian mode (`big_endian` = 0), an access of `n` bytes at offset `o` enables lanes `o` through `o+n-1` of `mem_be`. Bit `k` of `mem_be` is lane `k`, which covers data bits `8k+7:8k`.
- R5: In big-endian mode (`big_endian` = 1), the same access enables lanes `4-n-o` through `3-o`.
- R6: `mem_wdata` carries the low `n` bytes of `req_wdata`, shifted up to the first enabled lane in natural bit order. Lanes that are not enabled are 0.
- R7: A load result is taken from `mem_rdata`, starting at the lane that R4 or R5 gives for the request, and is right-justified in `load_data`.
- R8: When `req_unsigned` = 1, a byte or halfword load result is zero-extended to 32 bits. When it is 0, the result is sign-extended from bit 7 or bit 15 of the loaded value.
- R9: `load_valid` is high for exactly the cycle after each accepted non-faulting load, and that cycle is when `mem_rdata` must hold the read word. `load_valid` stays low after stores and after faulting or absent requests, and `load_data` is 0 whenever `load_valid` is low.
- R10: `mem_addr` equals `req_addr` with bits 1:0 cleared. `mem_we` equals `req_write` for any access that does not fault.
- R11: After reset, `load_valid`, `load_data`, `mem_req` and `fault` are low until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_unsigned | input | 1 | 1 = zero-extend a load, 0 = sign-extend |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store value, right-justified |
| big_endian | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| mem_req | output | 1 | Memory access issued |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Memory read word, one cycle after the request |
| fault | output | 1 | Misaligned or reserved-size access |
| load_valid | output | 1 | Load result valid this cycle |
| load_data | output | 32 | Extended load result |

## Verification
The assertions assume that every input is driven to a known value from reset onward, and that `mem_rdata` holds the addressed word during the cycle after a load request. They make no other assumption about the order of requests, so faulting, back-to-back and idle cycles may mix freely. The stimulus changes inputs only on falling clock edges. It places the memory word on `mem_rdata` exactly one cycle after each load. It covers both byte orders for every size at offsets that are legal and offsets that are not, plus the reserved size code.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_LOAD_WAIT = 1'b1
    } lsu_state_e;

    // Number of bytes moved by an access of the given size; 0 for the reserved code.
    function automatic int unsigned size_to_bytes(acc_size_e s);
        unique case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import lsu_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned OFF_W = $clog2(LANES),
    localparam int unsigned CNT_W = OFF_W + 2
) (
    input  acc_size_e          size_i,
    input  logic [OFF_W-1:0]   offset_i,
    input  logic               big_endian_i,
    output logic               misaligned_o,
    output logic [OFF_W-1:0]   lane_base_o,
    output logic [LANES-1:0]   lane_mask_o
);

    logic [CNT_W-1:0] n_bytes;
    logic [CNT_W-1:0] low_bits_mask;
    logic [CNT_W-1:0] be_base;
    logic [CNT_W-1:0] base_wide;

    always_comb begin
        n_bytes       = CNT_W'(size_to_bytes(size_i));
        low_bits_mask = (n_bytes == '0) ? '0 : (n_bytes - 1'b1);
        misaligned_o  = (size_i == SZ_BAD)
                     || ((CNT_W'(offset_i) & low_bits_mask) != '0)
                     || (n_bytes > CNT_W'(LANES));
        // mirrored lane start for big-endian order
        be_base     = CNT_W'(LANES) - n_bytes - CNT_W'(offset_i);
        base_wide   = big_endian_i ? be_base : CNT_W'(offset_i);
        lane_base_o = base_wide[OFF_W-1:0];
    end

    // One comparator pair per lane: enabled when inside [base, base+n).
    for (genvar k = 0; k < LANES; k++) begin : g_lane_mask
        assign lane_mask_o[k] = (CNT_W'(k) >= CNT_W'(lane_base_o))
                             && (CNT_W'(k) <  CNT_W'(lane_base_o) + n_bytes);
    end

    // Byte accesses are legal everywhere (R1)
    always_comb begin
        if (size_i == SZ_BYTE) begin
            assert_byte_legal_R1: assert (!misaligned_o);
        end
    end

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [OFF_W-1:0]  lane_base_i,
    input  logic [LANES-1:0]  lane_en_i,
    output logic [DATA_W-1:0] wdata_o
);

    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = wdata_i << {lane_base_i, 3'b000};
    end

    for (genvar k = 0; k < LANES; k++) begin : g_store_lane
        assign wdata_o[8*k +: 8] = lane_en_i[k] ? shifted[8*k +: 8] : 8'h00;
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(LANES),
    localparam int unsigned CNT_W = OFF_W + 2
) (
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [OFF_W-1:0]  lane_base_i,
    input  acc_size_e         size_i,
    input  logic              unsigned_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] shifted;
    logic [CNT_W-1:0]  n_bytes;
    logic              sign_bit;
    logic              fill;

    always_comb begin
        shifted = rdata_i >> {lane_base_i, 3'b000};
        n_bytes = CNT_W'(size_to_bytes(size_i));
        unique case (size_i)
            SZ_BYTE: sign_bit = shifted[7];
            SZ_HALF: sign_bit = shifted[15];
            default: sign_bit = 1'b0;
        endcase
        fill = sign_bit & ~unsigned_i;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_load_lane
        assign data_o[8*k +: 8] = (CNT_W'(k) < n_bytes) ? shifted[8*k +: 8] : {8{fill}};
    end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              big_endian,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fault,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_data
);

    acc_size_e          size_e;
    logic               misaligned;
    logic [OFF_W-1:0]   lane_base;
    logic [LANES-1:0]   lane_mask;
    logic               go;
    logic               accept_load;

    lsu_state_e         state_q, state_d;
    logic [OFF_W-1:0]   pend_base_q;
    acc_size_e          pend_size_q;
    logic               pend_uns_q;
    logic [DATA_W-1:0]  extracted;

    assign size_e = acc_size_e'(req_size);

    lsu_align_check #(.LANES(LANES)) u_align (
        .size_i       (size_e),
        .offset_i     (req_addr[OFF_W-1:0]),
        .big_endian_i (big_endian),
        .misaligned_o (misaligned),
        .lane_base_o  (lane_base),
        .lane_mask_o  (lane_mask)
    );

    always_comb begin
        fault       = req_valid & misaligned;
        go          = req_valid & ~misaligned;
        accept_load = go & ~req_write;
        mem_req     = go;
        mem_we      = go & req_write;
        mem_be      = go ? lane_mask : '0;
        mem_addr    = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

    lsu_store_lane #(.DATA_W(DATA_W)) u_store (
        .wdata_i     (req_wdata),
        .lane_base_i (lane_base),
        .lane_en_i   (mem_be),
        .wdata_o     (mem_wdata)
    );

    // Next-state: accept_load enters/holds ST_LOAD_WAIT, drain returns to ST_IDLE.
    always_comb begin
        unique case (state_q)
            ST_IDLE:      state_d = accept_load ? ST_LOAD_WAIT : ST_IDLE;
            ST_LOAD_WAIT: state_d = accept_load ? ST_LOAD_WAIT : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_base_q <= '0;
            pend_size_q <= SZ_BYTE;
            pend_uns_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_load) begin
                pend_base_q <= lane_base;
                pend_size_q <= size_e;
                pend_uns_q  <= req_unsigned;
            end
        end
    end

    lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
        .rdata_i     (mem_rdata),
        .lane_base_i (pend_base_q),
        .size_i      (pend_size_q),
        .unsigned_i  (pend_uns_q),
        .data_o      (extracted)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                load_valid = 1'b0;
                load_data  = '0;
            end
            ST_LOAD_WAIT: begin
                load_valid = 1'b1;
                load_data  = extracted;
            end
            default: begin
                load_valid = 1'b0;
                load_data  = '0;
            end
        endcase
    end

    // ---------------- assertions ----------------
    assert_fault_blocks_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (mem_be == '0 && !mem_req && !mem_we));

    assert_fault_no_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !(req_valid && !req_write && !fault)) |=> !load_valid);

    assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd2 && req_addr[1:0] != 2'b00) |-> fault);

    assert_half_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd1) |-> (fault == req_addr[0]));

    assert_enable_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == (1 << req_size)));

    assert_load_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !fault) |=> load_valid);

    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write && !fault) |=> !load_valid);

    assert_addr_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[OFF_W-1:0] == '0);

endmodule

// File: tb/lsu_lane_unit_tb_top.sv
module lsu_lane_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        big_endian = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_req, mem_we, fault, load_valid;
    logic [31:0] mem_addr, mem_wdata, load_data;
    logic [3:0]  mem_be;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_lane_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
        .req_wdata(req_wdata), .big_endian(big_endian), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .fault(fault), .load_valid(load_valid), .load_data(load_data)
    );

    typedef struct packed {
        logic        we;
        logic [1:0]  sz;
        logic        uns;
        logic        be;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic        xf;
        logic [3:0]  xbe;
        logic [31:0] xwd;
        logic [31:0] xld;
    } vec_t;

    // rdata 0xA1B2C3D4: lane0=D4 lane1=C3 lane2=B2 lane3=A1
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd0, 1'b0, 1'b0, 32'h100, 32'h0, 32'hA1B2C3D4, 1'b0, 4'b0001, 32'h0, 32'hFFFFFFD4},
        '{1'b0, 2'd0, 1'b1, 1'b0, 32'h103, 32'h0, 32'hA1B2C3D4, 1'b0, 4'b1000, 32'h0, 32'h000000A1},
        '{1'b0, 2'd0, 1'b0, 1'b1, 32'h103, 32'h0, 32'hA1B2C3D4, 1'b0, 4'b0001, 32'h0, 32'hFFFFFFD4},
        '{1'b0, 2'd0, 1'b1, 1'b1, 32'h101, 32'h0, 32'hA1B2C3D4, 1'b0, 4'b0100, 32'h0, 32'h000000B2},
        '{1'b0, 2'd1, 1'b0, 1'b0, 32'h102, 32'h0, 32'hA1B2C3D4, 1'b0, 4'b1100, 32'h0, 32'hFFFFA1B2},
        '{1'b0, 2'd1, 1'b1, 1'b0, 32'h100, 32'h0, 32'hA1B2C3D4, 1'b0, 4'b0011, 32'h0, 32'h0000C3D4},
        '{1'b0, 2'd1, 1'b1, 1'b1, 32'h100, 32'h0, 32'hA1B2C3D4, 1'b0, 4'b1100, 32'h0, 32'h0000A1B2},
        '{1'b0, 2'd1, 1'b0, 1'b1, 32'h102, 32'h0, 32'hA1B2C3D4, 1'b0, 4'b0011, 32'h0, 32'hFFFFC3D4},
        '{1'b0, 2'd2, 1'b0, 1'b0, 32'h104, 32'h0, 32'hA1B2C3D4, 1'b0, 4'b1111, 32'h0, 32'hA1B2C3D4},
        '{1'b0, 2'd2, 1'b1, 1'b1, 32'h108, 32'h0, 32'hA1B2C3D4, 1'b0, 4'b1111, 32'h0, 32'hA1B2C3D4},
        '{1'b0, 2'd1, 1'b0, 1'b0, 32'h101, 32'h0, 32'hA1B2C3D4, 1'b1, 4'b0000, 32'h0, 32'h0},
        '{1'b0, 2'd2, 1'b0, 1'b1, 32'h102, 32'h0, 32'hA1B2C3D4, 1'b1, 4'b0000, 32'h0, 32'h0},
        '{1'b0, 2'd2, 1'b0, 1'b0, 32'h103, 32'h0, 32'hA1B2C3D4, 1'b1, 4'b0000, 32'h0, 32'h0},
        '{1'b0, 2'd3, 1'b0, 1'b0, 32'h100, 32'h0, 32'hA1B2C3D4, 1'b1, 4'b0000, 32'h0, 32'h0},
        '{1'b1, 2'd0, 1'b0, 1'b0, 32'h101, 32'h11223344, 32'h0, 1'b0, 4'b0010, 32'h00004400, 32'h0},
        '{1'b1, 2'd0, 1'b0, 1'b1, 32'h101, 32'h11223344, 32'h0, 1'b0, 4'b0100, 32'h00440000, 32'h0},
        '{1'b1, 2'd1, 1'b0, 1'b0, 32'h102, 32'h11223344, 32'h0, 1'b0, 4'b1100, 32'h33440000, 32'h0},
        '{1'b1, 2'd1, 1'b0, 1'b1, 32'h102, 32'h11223344, 32'h0, 1'b0, 4'b0011, 32'h00003344, 32'h0},
        '{1'b1, 2'd1, 1'b0, 1'b1, 32'h103, 32'h11223344, 32'h0, 1'b1, 4'b0000, 32'h00000000, 32'h0},
        '{1'b0, 2'd0, 1'b0, 1'b0, 32'h102, 32'h0, 32'h007F0000, 1'b0, 4'b0100, 32'h0, 32'h0000007F}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        req_valid    = 1'b1;
        req_write    = v.we;
        req_size     = v.sz;
        req_unsigned = v.uns;
        big_endian   = v.be;
        req_addr     = v.addr;
        req_wdata    = v.wdata;
        #1;
        check(v.sz == 2'd0 ? "R1 fault" : "R2 fault", {31'b0, fault}, {31'b0, v.xf});
        check(v.be ? "R5 mem_be" : "R4 mem_be", {28'b0, mem_be}, {28'b0, v.xbe});
        check(v.xf ? "R3 mem_wdata" : "R6 mem_wdata", mem_wdata, v.xwd);
        check("R10 mem_addr", mem_addr, v.addr & 32'hFFFF_FFFC);
        check(v.xf ? "R3 mem_we" : "R10 mem_we", {31'b0, mem_we}, {31'b0, v.we & ~v.xf});
        @(negedge clk);
        req_valid = 1'b0;
        mem_rdata = v.rdata;
        #1;
        if (!v.we && !v.xf) begin
            check("R9 load_valid", {31'b0, load_valid}, 32'd1);
            check(v.uns ? "R8 zero-extend R7" : "R8 sign-extend R7", load_data, v.xld);
        end else begin
            check(v.xf ? "R3 no result" : "R9 no result", {31'b0, load_valid}, 32'd0);
            check("R9 load_data idle", load_data, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R11 load_valid", {31'b0, load_valid}, 32'd0);
        check("R11 load_data", load_data, 32'd0);
        check("R11 mem_req", {31'b0, mem_req}, 32'd0);
        check("R11 fault", {31'b0, fault}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
        end

        // R2: misaligned address with no request does not fault
        @(negedge clk);
        req_valid = 1'b0; req_size = 2'd2; req_addr = 32'h203;
        #1;
        check("R2 idle no fault", {31'b0, fault}, 32'd0);
        check("R3 idle no enables", {28'b0, mem_be}, 32'd0);

        // R9: back-to-back loads, little-endian then big-endian
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'd0; req_unsigned = 1'b1;
        big_endian = 1'b0; req_addr = 32'h301;
        @(negedge clk);
        mem_rdata = 32'h55667788;
        big_endian = 1'b1; req_addr = 32'h300; req_size = 2'd1; req_unsigned = 1'b0;
        #1;
        check("R9 back-to-back first valid", {31'b0, load_valid}, 32'd1);
        check("R7 back-to-back first data", load_data, 32'h00000077);
        @(negedge clk);
        req_valid = 1'b0;
        mem_rdata = 32'h8001_1234;
        #1;
        check("R9 back-to-back second valid", {31'b0, load_valid}, 32'd1);
        check("R8 back-to-back second data", load_data, 32'hFFFF8001);
        @(negedge clk);
        #1;
        check("R9 drain", {31'b0, load_valid}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule